// File: doc/BRIEF.md
# Serial Controller Processor Bus Front End

This block is the processor-facing side of a programmable serial transmitter/receiver. A processor reaches it through an active-low chip select, separate active-low read and write strobes and a one-bit path select. The select picks either the data path, which carries received or outgoing characters, or the control path, which carries configuration words in and the status word out. The 8-bit bidirectional bus is split into an input, an output and an output enable, which a pad ring combines into one tri-state bus.

After reset the block is idle and holds nothing. It leaves idle only once a configuration pair has been written on the control path: a mode word followed by a command word. A command carrying the internal-reset bit sends it back to idle to wait for a new mode word. The serial engines are outside the block. On the transmit side it presents its one-character holding slot as a valid/ready source. When `tx_valid` is high, `tx_data` stays stable until `tx_ready` is sampled high, except that a processor write overwrites the slot. On the receive side it accepts one character at a time from a valid/ready sink. `rx_ready` drops while the receive slot is full or the block is idle, and the upstream receiver must hold `rx_valid` and `rx_data` until both are high.

Top module: `sif_bus_front`

## Requirements
- R1: While `cs_n` is high, no write changes any register and `bus_oe` is low.
- R2: With `cs_n`=0, `cd`=0, `rd_n`=0 and `wr_n`=1, `bus_oe` is high in the same cycle and `bus_out` shows the received character held in the receive slot. `bus_out` is zero whenever `bus_oe` is low.
- R3: With `cs_n`=0, `cd`=1, `rd_n`=0 and `wr_n`=1, `bus_out` shows the status word. Bit 0 is the transmit slot full flag, bit 1 the receive slot full flag, bit 2 the idle flag, and bits 7:3 copy `ext_stat[4:0]`.
- R4: Reset (`rst` high) clears `mode_q`, `cmd_q`, both slots and their flags, and forces `idle` high. `tx_valid` and `rx_ready` stay low while idle.
- R5: A write takes effect at the clock edge that first samples a qualified strobe (`cs_n`=0, `wr_n`=0, `rd_n`=1). A strobe held for several cycles writes once. On the control path (`cd`=1), the first write after reset or after an internal reset loads `mode_q`. Each later one is a command: without bit 6 set it loads `cmd_q`, and the first such command clears `idle`.
- R6: A command with bit 6 set (internal reset) leaves `cmd_q` unchanged, sets `idle`, empties both slots and makes the next control write load `mode_q`.
- R7: With `rd_n` and `wr_n` both low, nothing is written and `bus_oe` stays low.
- R8: A data-path write while not idle loads `bus_in` into the transmit slot and raises `tx_valid` with `tx_data` equal to it. A data-path write while idle is ignored.
- R9: `tx_valid` with `tx_ready` high empties the transmit slot at that edge. If a data write lands on the same edge, the slot stays full with the new character.
- R10: `rx_ready` is high exactly when the block is not idle and the receive slot is empty. `rx_valid` with `rx_ready` loads `rx_data` and marks the slot full.
- R11: A data-path read empties the receive slot at the edge that first samples the strobe released. During the strobe the slot stays full and its character stays on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd | input | 1 | Path select: 1 control/status, 0 data |
| bus_in | input | DW | Bus value written by the processor |
| bus_out | output | DW | Bus value read by the processor |
| bus_oe | output | 1 | Drive enable for `bus_out` |
| ext_stat | input | DW-3 | Status bits from the serial engines |
| tx_valid | output | 1 | Transmit slot holds a character |
| tx_ready | input | 1 | Transmitter takes the character |
| tx_data | output | DW | Transmit character |
| rx_valid | input | 1 | Receiver offers a character |
| rx_ready | output | 1 | Receive slot can accept |
| rx_data | input | DW | Received character |
| mode_q | output | DW | Mode register |
| cmd_q | output | DW | Command register |
| idle | output | 1 | Block is waiting for configuration |

## Verification
Every cycle, the assertions check the protections that hold at any edge: a deselected or colliding access never drives the bus or changes configuration, idle never offers or accepts a character, a pending transmit character holds still until taken, a receive handshake closes the slot, and idle only ends through a control write. The order of the mode and command writes, the write-once behaviour of long strobes, the clearing of the receive flag when the read ends, and the internal-reset sequence depend on a history of accesses. Only the bench's reference model and its directed scenarios can show these.

// File: rtl/sif_pkg.sv
`timescale 1ns/1ps
package sif_pkg;
  typedef enum logic [1:0] {
    PH_MODE = 2'd0,
    PH_CMD  = 2'd1,
    PH_RUN  = 2'd2
  } phase_e;

  localparam int ST_TXF     = 0;
  localparam int ST_RXF     = 1;
  localparam int ST_IDLE    = 2;
  localparam int ST_EXT_LSB = 3;
endpackage

// File: rtl/sif_access.sv
`timescale 1ns/1ps
module sif_access (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic cd,
  output logic ctl_wr,
  output logic dat_wr,
  output logic dat_rd_done,
  output logic rd_en
);
  logic wr_req, rd_req, drd_req;
  logic wr_req_q, drd_req_q;

  // Strobe decode; both strobes low is treated as no access
  assign wr_req  = !cs_n && !wr_n && rd_n;
  assign rd_req  = !cs_n && !rd_n && wr_n;
  assign drd_req = rd_req && !cd;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_req_q  <= 1'b0;
      drd_req_q <= 1'b0;
    end else begin
      wr_req_q  <= wr_req;
      drd_req_q <= drd_req;
    end
  end

  // Leading edge of a write, trailing edge of a data read
  assign ctl_wr      = wr_req && !wr_req_q && cd;
  assign dat_wr      = wr_req && !wr_req_q && !cd;
  assign dat_rd_done = drd_req_q && !drd_req;
  assign rd_en       = rd_req;
endmodule

// File: rtl/sif_cfg_seq.sv
`timescale 1ns/1ps
module sif_cfg_seq #(
  parameter int DW       = 8,
  parameter int IRST_BIT = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] cmd_q,
  output logic          idle,
  output logic          soft_clr
);
  import sif_pkg::*;

  phase_e phase_q;
  logic   is_cmd;

  assign is_cmd   = ctl_wr && (phase_q != PH_MODE);
  assign soft_clr = is_cmd && wdata[IRST_BIT];
  assign idle     = (phase_q != PH_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_MODE;
      mode_q  <= '0;
      cmd_q   <= '0;
    end else if (ctl_wr) begin
      if (phase_q == PH_MODE) begin
        mode_q  <= wdata;
        phase_q <= PH_CMD;
      end else if (wdata[IRST_BIT]) begin
        phase_q <= PH_MODE;
      end else begin
        cmd_q   <= wdata;
        phase_q <= PH_RUN;
      end
    end
  end
endmodule

// File: rtl/sif_tx_slot.sv
`timescale 1ns/1ps
module sif_tx_slot #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  output logic          full
);
  logic full_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (clr) begin
      full_q <= 1'b0;
    end else if (load && en) begin
      full_q <= 1'b1;
      data_q <= load_data;
    end else if (full_q && tx_ready) begin
      full_q <= 1'b0;
    end
  end

  assign full     = full_q;
  assign tx_valid = full_q;
  assign tx_data  = data_q;
endmodule

// File: rtl/sif_rx_slot.sv
`timescale 1ns/1ps
module sif_rx_slot #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic          take,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [DW-1:0] rx_data,
  output logic [DW-1:0] hold,
  output logic          full
);
  logic full_q;
  logic [DW-1:0] data_q;

  assign rx_ready = en && !full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (clr) begin
      full_q <= 1'b0;
    end else if (rx_valid && rx_ready) begin
      full_q <= 1'b1;
      data_q <= rx_data;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  assign hold = data_q;
  assign full = full_q;
endmodule

// File: rtl/sif_bus_front.sv
`timescale 1ns/1ps
module sif_bus_front #(
  parameter int DW       = 8,
  parameter int IRST_BIT = 6,
  localparam int EXTW    = DW - 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs_n,
  input  logic            rd_n,
  input  logic            wr_n,
  input  logic            cd,
  input  logic [DW-1:0]   bus_in,
  output logic [DW-1:0]   bus_out,
  output logic            bus_oe,
  input  logic [EXTW-1:0] ext_stat,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic [DW-1:0]   tx_data,
  input  logic            rx_valid,
  output logic            rx_ready,
  input  logic [DW-1:0]   rx_data,
  output logic [DW-1:0]   mode_q,
  output logic [DW-1:0]   cmd_q,
  output logic            idle
);
  import sif_pkg::*;

  logic ctl_wr, dat_wr, dat_rd_done, rd_en;
  logic soft_clr, tx_full, rx_full;
  logic [DW-1:0] rx_hold, status;

  sif_access u_access (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .cd(cd),
    .ctl_wr(ctl_wr), .dat_wr(dat_wr), .dat_rd_done(dat_rd_done), .rd_en(rd_en)
  );

  sif_cfg_seq #(.DW(DW), .IRST_BIT(IRST_BIT)) u_cfg (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .wdata(bus_in),
    .mode_q(mode_q), .cmd_q(cmd_q), .idle(idle), .soft_clr(soft_clr)
  );

  sif_tx_slot #(.DW(DW)) u_tx (
    .clk(clk), .rst(rst), .clr(soft_clr), .en(!idle), .load(dat_wr),
    .load_data(bus_in), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .full(tx_full)
  );

  sif_rx_slot #(.DW(DW)) u_rx (
    .clk(clk), .rst(rst), .clr(soft_clr), .en(!idle), .take(dat_rd_done),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .hold(rx_hold), .full(rx_full)
  );

  always_comb begin
    status = '0;
    status[ST_TXF]  = tx_full;
    status[ST_RXF]  = rx_full;
    status[ST_IDLE] = idle;
    status[DW-1:ST_EXT_LSB] = ext_stat;
  end

  assign bus_oe  = rd_en;
  assign bus_out = rd_en ? (cd ? status : rx_hold) : '0;
endmodule

// File: rtl/sif_bus_front_chk.sv
`timescale 1ns/1ps
module sif_bus_front_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic          cd,
  input logic          bus_oe,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [DW-1:0] tx_data,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [DW-1:0] mode_q,
  input logic [DW-1:0] cmd_q,
  input logic          idle
);
  // R1
  cs_hi_float_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !bus_oe);
  // R1
  cs_hi_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> ($stable(mode_q) && $stable(cmd_q)));
  // R7
  collide_float_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && !wr_n) |-> !bus_oe);
  // R7
  collide_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && !wr_n) |=> ($stable(mode_q) && $stable(cmd_q)));
  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    idle |-> (!tx_valid && !rx_ready));
  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && (cs_n || wr_n)) |=> (tx_valid && $stable(tx_data)));
  // R10
  rx_take_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_ready) |=> !rx_ready);
  // R5
  idle_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(idle) |-> $past(!cs_n && !wr_n && rd_n && cd));
endmodule

bind sif_bus_front sif_bus_front_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .cd(cd),
  .bus_oe(bus_oe), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .mode_q(mode_q), .cmd_q(cmd_q),
  .idle(idle)
);

// File: tb/test_sif_bus_front.sv
`timescale 1ns/1ps
module test_sif_bus_front;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd = 1'b0;
  logic [7:0] bus_in = '0;
  logic [4:0] ext_stat = '0;
  logic tx_ready = 1'b0, rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic [7:0] bus_out, tx_data, mode_q, cmd_q;
  logic bus_oe, tx_valid, rx_ready, idle;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sif_bus_front i_sif_bus_front (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .cd(cd),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .ext_stat(ext_stat),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .mode_q(mode_q), .cmd_q(cmd_q), .idle(idle)
  );

  // Reference model: behavioural state, updated from sampled inputs
  int   m_phase = 0;          // 0 wait mode, 1 wait command, 2 running
  logic [7:0] m_mode = 0, m_cmd = 0, m_txd = 0, m_rxd = 0;
  bit   m_txf = 0, m_rxf = 0, m_pw = 0, m_prd = 0;

  always @(posedge clk) begin
    bit wreq, rreq, wfire, rend, run;
    wreq = !cs_n && !wr_n && rd_n;
    rreq = !cs_n && !rd_n && wr_n && !cd;
    wfire = wreq && !m_pw;
    rend = m_prd && !rreq;
    run = (m_phase == 2);
    if (rst) begin
      m_phase = 0; m_mode = 0; m_cmd = 0; m_txd = 0; m_rxd = 0;
      m_txf = 0; m_rxf = 0; m_pw = 0; m_prd = 0;
    end else begin
      if (wfire && cd && m_phase != 0 && bus_in[6]) begin
        m_phase = 0; m_txf = 0; m_rxf = 0;
      end else begin
        if (wfire && cd) begin
          if (m_phase == 0) begin m_mode = bus_in; m_phase = 1; end
          else begin m_cmd = bus_in; m_phase = 2; end
        end
        if (wfire && !cd && run) begin m_txf = 1; m_txd = bus_in; end
        else if (m_txf && tx_ready) m_txf = 0;
        if (run && !m_rxf && rx_valid) begin m_rxf = 1; m_rxd = rx_data; end
        else if (rend) m_rxf = 0;
      end
      m_pw = wreq; m_prd = rreq;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Advance to the next falling edge and compare every output with the model
  task automatic cyc();
    logic oe_e;
    logic [7:0] st, bo;
    @(negedge clk);
    oe_e = !cs_n && !rd_n && wr_n;
    st = {ext_stat, (m_phase != 2), m_rxf, m_txf};
    bo = oe_e ? (cd ? st : m_rxd) : 8'h00;
    if (!rst) begin
      chk("R1/R7 bus_oe", {7'd0, bus_oe}, {7'd0, oe_e});
      chk("R2/R3 bus_out", bus_out, bo);
      chk("R8 tx_valid", {7'd0, tx_valid}, {7'd0, m_txf});
      if (m_txf) chk("R8 tx_data", tx_data, m_txd);
      chk("R10 rx_ready", {7'd0, rx_ready}, {7'd0, (m_phase == 2) && !m_rxf});
      chk("R5 mode_q", mode_q, m_mode);
      chk("R5 cmd_q", cmd_q, m_cmd);
      chk("R4 idle", {7'd0, idle}, {7'd0, m_phase != 2});
    end
  endtask

  task automatic bus_wr(logic sel, logic [7:0] v);
    cs_n = 0; wr_n = 0; rd_n = 1; cd = sel; bus_in = v;
    cyc(); cyc();
    cs_n = 1; wr_n = 1;
    cyc();
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst = 0;
    cyc();
    // R4 reset state
    chk("R4 idle after reset", {7'd0, idle}, 8'd1);
    chk("R4 mode_q after reset", mode_q, 8'h00);
    chk("R4 rx_ready after reset", {7'd0, rx_ready}, 8'd0);
    // R1 deselected write/read
    cs_n = 1; wr_n = 0; cd = 1; bus_in = 8'hA5; cyc(); cyc();
    chk("R1 no write when deselected", mode_q, 8'h00);
    wr_n = 1; rd_n = 0; cyc();
    chk("R1 bus floats when deselected", {7'd0, bus_oe}, 8'd0);
    rd_n = 1; cyc();
    // R7 both strobes low
    cs_n = 0; rd_n = 0; wr_n = 0; cd = 1; bus_in = 8'h5A; cyc(); cyc();
    chk("R7 collide no drive", {7'd0, bus_oe}, 8'd0);
    chk("R7 collide no write", mode_q, 8'h00);
    cs_n = 1; rd_n = 1; wr_n = 1; cyc();
    // R5 mode then command, long strobe writes once
    bus_wr(1, 8'h4E);
    chk("R5 mode loaded", mode_q, 8'h4E);
    chk("R5 still idle after mode", {7'd0, idle}, 8'd1);
    bus_wr(1, 8'h15);
    chk("R5 command loaded", cmd_q, 8'h15);
    chk("R5 idle cleared", {7'd0, idle}, 8'd0);
    // R8 data write
    bus_wr(0, 8'h3C);
    chk("R8 tx_valid", {7'd0, tx_valid}, 8'd1);
    chk("R8 tx_data", tx_data, 8'h3C);
    // R3 status layout
    ext_stat = 5'b10101; cs_n = 0; rd_n = 0; cd = 1; cyc();
    chk("R3 status word", bus_out, 8'hA9);
    cs_n = 1; rd_n = 1; cyc();
    // R9 handshake with a simultaneous write
    tx_ready = 1; cs_n = 0; wr_n = 0; cd = 0; bus_in = 8'h22; cyc();
    chk("R9 overlap keeps slot full", {7'd0, tx_valid}, 8'd1);
    chk("R9 overlap new data", tx_data, 8'h22);
    cs_n = 1; wr_n = 1; cyc();
    chk("R9 handshake empties slot", {7'd0, tx_valid}, 8'd0);
    tx_ready = 0;
    // R10 receive handshake
    rx_valid = 1; rx_data = 8'h5A; cyc();
    rx_valid = 0;
    chk("R10 slot full blocks ready", {7'd0, rx_ready}, 8'd0);
    // R11 data read clears at strobe end; R2 data on bus
    cs_n = 0; rd_n = 0; cd = 0; cyc();
    chk("R2 data read drives bus", bus_out, 8'h5A);
    cyc();
    chk("R11 flag held during read", {7'd0, rx_ready}, 8'd0);
    cs_n = 1; rd_n = 1; cyc();
    chk("R11 flag cleared after read", {7'd0, rx_ready}, 8'd1);
    // R6 internal reset
    bus_wr(0, 8'h99);
    bus_wr(1, 8'h40);
    chk("R6 idle after internal reset", {7'd0, idle}, 8'd1);
    chk("R6 cmd_q unchanged", cmd_q, 8'h15);
    chk("R6 tx slot emptied", {7'd0, tx_valid}, 8'd0);
    bus_wr(0, 8'h77);
    chk("R8 write ignored while idle", {7'd0, tx_valid}, 8'd0);
    bus_wr(1, 8'hCC);
    chk("R6 next control write is mode", mode_q, 8'hCC);
    bus_wr(1, 8'h05);
    chk("R6 running again", {7'd0, idle}, 8'd0);
    // Random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      cs_n = (r < 15);
      rd_n = $urandom_range(0, 2) != 0;
      wr_n = $urandom_range(0, 3) != 0;
      cd = (r > 85);
      bus_in = 8'($urandom) & 8'hBF;
      if (r == 50) bus_in = 8'h40;
      ext_stat = 5'($urandom);
      tx_ready = $urandom_range(0, 1) != 0;
      rx_valid = $urandom_range(0, 1) != 0;
      rx_data = 8'($urandom);
      cyc();
    end
    cs_n = 1; rd_n = 1; wr_n = 1; cyc();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule